// File: doc/BRIEF.md
# Banked Interrupt Collector

This block is one bank of an interrupt controller. It watches 32 interrupt source lines and latches a pending bit for each source on that line's rising edge. An enable word gates the pending bits, which gives a masked output word. The OR of the masked output word drives one request line to the processor. A priority helper reports the index of the most significant masked pending bit, so the service routine can handle that source first.

Software reaches the bank through a flat register port: address, write data, write strobe and a combinational read-data word. The port offers five word registers at fixed offsets inside the bank window. The bank window starts at `BANK_IDX * 0x28`, so several instances with different `BANK_IDX` values can share one address space. The register port is a plain control interface with single-cycle writes and no back-pressure, so it has no valid/ready handshake. The source lines and the request outputs are plain level signals.

Top module: `intc_bank`

## Requirements
- R1: After reset the pending, enable and spare registers read zero, and `irq_o` and `top_vld_o` are low.
- R2: A 0-to-1 transition on `src_i[i]`, sampled at a clock edge, sets pending bit i at that edge. A line held high does not set the bit again once the bit has been cleared. The bit is set again only after the line goes low and then high.
- R3: A write to the pending register (offset 0x00) clears every bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing all ones clears all pending bits.
- R4: If a rising edge and a clear for the same pending bit fall in the same cycle, the bit ends up set.
- R5: The output word (offset 0x10) equals the pending word ANDed with the enable word. It reads zero when no enabled source is pending.
- R6: `irq_o` is high exactly when the output word is non-zero.
- R7: A write to the enable register (offset 0x08) replaces the whole word. Writing zero disables all sources and drops `irq_o`.
- R8: The raw register (offset 0x18) reads the present level of `src_i`, with no latching.
- R9: The spare register (offset 0x20) can be written and read back. It has no effect on pending bits, the output word or `irq_o`.
- R10: `top_idx_o` gives the index of the most significant set bit of the output word, and `top_vld_o` is high whenever that word is non-zero.
- R11: Offsets are taken relative to the bank base `BANK_IDX*0x28`. Addresses outside the bank window read zero and are ignored on write. Writes to the output (0x10) and raw (0x18) offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source lines, one per bit |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined request to the processor |
| top_idx_o | output | 5 | Index of the highest masked pending source |
| top_vld_o | output | 1 | High when `top_idx_o` is meaningful |

## Verification
The bench collides a clear with a fresh rising edge on the same bit. A design that lets the clear win would silently lose that interrupt. It holds a source high across a clear, which catches a design that treats the line as a level and re-asserts it forever. It also places active bits at both ends of the word and next to disabled bits, so an encoder that picks the lowest bit, or ignores the enable, reports the wrong index. The bench instantiates the bank at a non-zero base and writes to the neighbouring bank's window and to the read-only offsets. A decoder that ignores the base, or a register that accepts those writes, changes state that the bench then reads back.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BANK_STRIDE = 40;  // 0x28 bytes per bank
  localparam int unsigned OFF_PEND    = 0;   // 0x00
  localparam int unsigned OFF_ENA     = 8;   // 0x08
  localparam int unsigned OFF_OUT     = 16;  // 0x10
  localparam int unsigned OFF_RAW     = 24;  // 0x18
  localparam int unsigned OFF_SPARE   = 32;  // 0x20

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENA,
    SEL_OUT,
    SEL_RAW,
    SEL_SPARE
  } reg_sel_e;
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_IDX = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int BASE = BANK_IDX * int'(BANK_STRIDE);

  int rel;

  always_comb begin
    rel = int'(addr) - BASE;
    sel = SEL_NONE;
    if (rel >= 0 && rel < int'(BANK_STRIDE)) begin
      case (rel)
        int'(OFF_PEND):  sel = SEL_PEND;
        int'(OFF_ENA):   sel = SEL_ENA;
        int'(OFF_OUT):   sel = SEL_OUT;
        int'(OFF_RAW):   sel = SEL_RAW;
        int'(OFF_SPARE): sel = SEL_SPARE;
        default:         sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc_pend_latch.sv
module intc_pend_latch #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;

  assign rise = src & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= (pend & ~clr) | rise;
    end
  end

  // R4: a collision between an edge and a clear keeps the bit set
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & clr) != '0) |=> ((pend & $past(rise & clr)) == $past(rise & clr)));

  // R3: cleared bits without a new edge read zero next cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != '0) |=> ((pend & $past(clr & ~rise)) == '0));

  // R2: a bit only becomes set following a rising edge
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(rise)) == '0));
endmodule

// File: rtl/intc_msb_enc.sv
module intc_msb_enc #(
  parameter int N_SRC = 32,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_IDX = 0,
  parameter int N_SRC    = 32,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              irq_o,
  output logic [IDX_W-1:0]  top_idx_o,
  output logic              top_vld_o
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] spare_q;
  logic [N_SRC-1:0] out_stat;

  intc_addr_dec #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  assign clr = (reg_we && sel == SEL_PEND) ? reg_wdata : '0;

  intc_pend_latch #(.N_SRC(N_SRC)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_i),
    .clr   (clr),
    .pend  (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      spare_q <= '0;
    end else if (reg_we) begin
      if (sel == SEL_ENA)   en_q    <= reg_wdata;
      if (sel == SEL_SPARE) spare_q <= reg_wdata;
    end
  end

  assign out_stat = pend & en_q;
  assign irq_o    = |out_stat;

  intc_msb_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_enc (
    .vec (out_stat),
    .idx (top_idx_o),
    .vld (top_vld_o)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:  reg_rdata = pend;
      SEL_ENA:   reg_rdata = en_q;
      SEL_OUT:   reg_rdata = out_stat;
      SEL_RAW:   reg_rdata = src_i;
      SEL_SPARE: reg_rdata = spare_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R6: request line and encoder agree
  p_req_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == top_vld_o);

  // R10: reported index points at a set output bit
  p_idx_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld_o |-> out_stat[top_idx_o]);

  // R10: nothing above the reported index is set
  p_idx_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld_o |-> ((out_stat >> top_idx_o) == N_SRC'(1)));

  // R7: all sources disabled means no request
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

// File: tb/intc_bank_tb.sv
module intc_bank_tb;
  localparam logic [7:0] B        = 8'h28;  // base of bank 1
  localparam logic [7:0] A_PEND   = B + 8'h00;
  localparam logic [7:0] A_ENA    = B + 8'h08;
  localparam logic [7:0] A_OUT    = B + 8'h10;
  localparam logic [7:0] A_RAW    = B + 8'h18;
  localparam logic [7:0] A_SPARE  = B + 8'h20;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [31:0] out;
    logic [4:0]  idx;
    logic        vld;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  1'b1},
    '{32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0001, 5'd31, 1'b1},
    '{32'h00F0_0000, 32'h0030_0000, 32'h0030_0000, 5'd21, 1'b1},
    '{32'h1234_5678, 32'h0000_0000, 32'h0000_0000, 5'd0,  1'b0},
    '{32'h0000_0C00, 32'h0000_0800, 32'h0000_0800, 5'd11, 1'b1},
    '{32'hFFFF_FFFF, 32'h4000_0000, 32'h4000_0000, 5'd30, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [4:0]  top_idx_o;
  logic        top_vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_bank #(.ADDR_W(8), .BANK_IDX(1), .N_SRC(32)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .top_idx_o (top_idx_o),
    .top_vld_o (top_vld_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    rd(A_PEND, d);  chk("R1 pend", d, 32'h0);
    rd(A_ENA, d);   chk("R1 enable", d, 32'h0);
    rd(A_SPARE, d); chk("R1 spare", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 vld", {31'b0, top_vld_o}, 32'h0);

    // Vector table: R5, R6, R10
    for (int k = 0; k < 6; k++) begin
      src_i = '0;
      wr(A_ENA, VECS[k].en);
      wr(A_PEND, 32'hFFFF_FFFF);
      src_i = VECS[k].src;
      tick();
      rd(A_OUT, d);  chk("R5 out word", d, VECS[k].out);
      rd(A_PEND, d); chk("R2 pend latched", d, VECS[k].src);
      chk("R6 irq", {31'b0, irq_o}, {31'b0, VECS[k].vld});
      chk("R10 vld", {31'b0, top_vld_o}, {31'b0, VECS[k].vld});
      if (VECS[k].vld) chk("R10 idx", {27'b0, top_idx_o}, {27'b0, VECS[k].idx});
    end

    // R3: partial clear then full clear
    src_i = '0;
    wr(A_ENA, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    src_i = 32'h0000_00F0;
    tick();
    wr(A_PEND, 32'h0000_0030);
    rd(A_PEND, d); chk("R3 partial clear", d, 32'h0000_00C0);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R3 clear all", d, 32'h0);
    chk("R3 irq after clear", {31'b0, irq_o}, 32'h0);

    // R2: held level does not re-set, new edge does
    tick(); tick();
    rd(A_PEND, d); chk("R2 held level", d, 32'h0);
    src_i = '0;
    tick();
    src_i = 32'h0000_0020;
    tick();
    rd(A_PEND, d); chk("R2 re-edge", d, 32'h0000_0020);

    // R4: edge and clear same cycle
    src_i = '0;
    wr(A_PEND, 32'hFFFF_FFFF);
    src_i = 32'h0000_0001;
    wr(A_PEND, 32'h0000_0001);
    rd(A_PEND, d); chk("R4 set wins", d, 32'h0000_0001);

    // R7: enable zero disables everything
    wr(A_ENA, 32'h0);
    chk("R7 irq off", {31'b0, irq_o}, 32'h0);
    rd(A_OUT, d); chk("R7 out zero", d, 32'h0);
    wr(A_ENA, 32'h0000_0001);
    chk("R7 irq on", {31'b0, irq_o}, 32'h1);

    // R8: raw level
    src_i = 32'hA5A5_5A5A;
    rd(A_RAW, d); chk("R8 raw", d, 32'hA5A5_5A5A);

    // R9: spare register read-back, no effect on output
    src_i = 32'h0000_0001;
    wr(A_SPARE, 32'hFFFF_FFFF);
    rd(A_SPARE, d); chk("R9 spare readback", d, 32'hFFFF_FFFF);
    rd(A_OUT, d);   chk("R9 out unchanged", d, 32'h0000_0001);
    chk("R9 irq unchanged", {31'b0, irq_o}, 32'h1);

    // R11: read-only offsets and the other bank's window
    wr(A_RAW, 32'h0);
    rd(A_RAW, d);  chk("R11 raw write ignored", d, 32'h0000_0001);
    wr(A_OUT, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R11 out write ignored", d, 32'h0000_0001);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R11 other bank write ignored", d, 32'h0000_0001);
    rd(8'h00, d);  chk("R11 other bank reads zero", d, 32'h0);
    rd(B + 8'h04, d); chk("R11 hole reads zero", d, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule